// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two thresholds used by a FIFO's flag logic: the empty offset, which sets the almost-empty threshold, and the full offset, which sets the almost-full threshold. On a master reset it loads a default pair of offsets. The level of the load input at that reset chooses the default value and fixes the programming method for every later access until the next master reset. Memory storage and the flag comparisons belong to neighbouring blocks. Those blocks take the offsets from `empty_ofs` and `full_ofs`, and take their memory-access qualifiers from `mem_wr_en` and `mem_rd_en`.

The block supports two programming methods. In parallel mode, the load input together with the write enable copies offsets from the data input bus on write-clock edges. In serial mode, each write-clock edge with the serial enable asserted shifts one bit in from the mode-select/serial-in pin. In either mode, the load input together with the read enable places the offsets, one per read-clock edge, on the data output bus. A partial reset keeps the offsets and the method. It only restarts the access sequences and clears the output register.

The write side is a four-state machine. The states are `WS_PAR_E` (the next parallel write goes to the empty offset), `WS_PAR_F` (the next parallel write goes to the full offset), `WS_SER_E` (serial bits are going into the empty offset) and `WS_SER_F` (serial bits are going into the full offset). The transitions are:
- `WS_PAR_E` to `WS_PAR_F` on a parallel write, and `WS_PAR_F` back to `WS_PAR_E` on the next one.
- `WS_SER_E` to `WS_SER_F` after the last bit of the empty offset, and `WS_SER_F` back to `WS_SER_E` after the last bit of the full offset.
- Master reset sends the machine to `WS_SER_E` or `WS_PAR_E` according to the load input.
- Partial reset sends it to the entry state of the latched method.

The read side has two states. `RS_EMPTY` is left for `RS_FULL` on a readback, and `RS_FULL` returns to `RS_EMPTY` on the next readback. Either reset returns it to `RS_EMPTY`.

Top module: `pfo_loader`

## Requirements
- R1: A write-clock edge with `mst_rst` high loads both offsets with a default. The default is 127 when `ld` is 0 and 1023 when `ld` is 1. A read-clock edge with `mst_rst` high clears `dout` to 0.
- R2: A master reset latches the programming method from `ld`: `serial_mode` becomes 0 (parallel) when `ld` is 0 and 1 (serial) when `ld` is 1. `serial_mode` holds that value until the next master reset.
- R3: In parallel mode, each write-clock edge with `ld` and `wen` high copies `din[OW-1:0]` into an offset. The writes alternate: empty offset first, then full offset. Upper bits of `din` are ignored, and at most one offset changes per edge.
- R4: Each read-clock edge with `ld` and `ren` high loads `dout` with one offset, zero-extended. The readbacks alternate: empty offset first, then full offset. With no readback, and no reset, `dout` holds its value.
- R5: In serial mode, each write-clock edge with `sen` high shifts `fwft_si` into the offsets, least significant bit first. The first OW bits fill the empty offset and the next OW bits fill the full offset. The sequence then restarts at the empty offset.
- R6: In serial mode, `ld` with `wen` and without `sen` changes neither offset. In parallel mode, `sen` changes neither offset.
- R7: A partial reset leaves both offsets and `serial_mode` unchanged and clears `dout`. It restarts both the write sequence (parallel order or serial bit position) and the readback sequence at the empty offset.
- R8: `mem_wr_en` equals `wen` while `ld` is 0 and is 0 while `ld` is 1. `mem_rd_en` follows the same rule for `ren`.
- R9: When `mst_rst` and `part_rst` are both high, the master reset takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mst_rst | input | 1 | Master reset, synchronous to each clock, active high |
| part_rst | input | 1 | Partial reset, synchronous to each clock, active high |
| ld | input | 1 | Default/method select during master reset; offset access gate afterwards |
| wen | input | 1 | Write enable |
| ren | input | 1 | Read enable |
| sen | input | 1 | Serial shift enable |
| fwft_si | input | 1 | Mode-select pin, used as the serial data input after reset |
| din | input | DW | Data input bus |
| dout | output | DW | Offset readback register |
| empty_ofs | output | OW | Empty offset to the almost-empty flag logic |
| full_ofs | output | OW | Full offset to the almost-full flag logic |
| serial_mode | output | 1 | Latched programming method, 1 = serial |
| mem_wr_en | output | 1 | Qualified memory write enable |
| mem_rd_en | output | 1 | Qualified memory read enable |

## Verification
A wrong write-side state puts a value into the other offset. The misrouting shows on `empty_ofs` or `full_ofs` one edge after the faulty write, or after the last bit of a serial load. A stale serial bit counter shifts the value left or right by whole bit positions. This appears as soon as one complete offset has been shifted in, and the bench checks the count again after a partial reset taken in mid-sequence. A wrong read-side toggle returns the two offsets in the wrong order on `dout` at the very next readback. A method latch that drifts shows on `serial_mode` and in whether parallel writes take effect.

// File: rtl/pfo_pkg.sv
package pfo_pkg;

    typedef enum logic [1:0] {
        WS_PAR_E = 2'd0,
        WS_PAR_F = 2'd1,
        WS_SER_E = 2'd2,
        WS_SER_F = 2'd3
    } wr_state_t;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_FULL  = 1'b1
    } rd_state_t;

    localparam int DEF_OFS_LO = 127;
    localparam int DEF_OFS_HI = 1023;

endpackage

// File: rtl/pfo_mode_latch.sv
module pfo_mode_latch (
    input  logic wclk,
    input  logic mst_rst,
    input  logic ld,
    output logic serial_mode
);

    logic mode_q;

    always_ff @(posedge wclk) begin
        if (mst_rst) begin
            mode_q <= ld;
        end
    end

    assign serial_mode = mode_q;

    AST_MODE_HOLD: assert property (@(posedge wclk) disable iff (mst_rst)
        !mst_rst |=> $stable(serial_mode)); // R2

endmodule

// File: rtl/pfo_wr_ctrl.sv
module pfo_wr_ctrl
    import pfo_pkg::*;
#(
    parameter int DW = 18,
    parameter int OW = 17
) (
    input  logic          wclk,
    input  logic          mst_rst,
    input  logic          part_rst,
    input  logic          ld,
    input  logic          wen,
    input  logic          sen,
    input  logic          fwft_si,
    input  logic          serial_mode,
    input  logic [DW-1:0] din,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs
);

    localparam int CW = (OW > 1) ? $clog2(OW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(OW - 1);
    localparam logic [OW-1:0] OFS_LO = OW'(DEF_OFS_LO);
    localparam logic [OW-1:0] OFS_HI = OW'(DEF_OFS_HI);

    wr_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [OW-1:0] e_q, e_d;
    logic [OW-1:0] f_q, f_d;
    logic          par_wr;
    logic [OW-1:0] par_val;

    assign par_wr  = ld && wen;
    assign par_val = din[OW-1:0];

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (mst_rst) begin
            st_d  = ld ? WS_SER_E : WS_PAR_E;
            cnt_d = '0;
        end else if (part_rst) begin
            st_d  = serial_mode ? WS_SER_E : WS_PAR_E;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                WS_PAR_E: if (par_wr) st_d = WS_PAR_F;
                WS_PAR_F: if (par_wr) st_d = WS_PAR_E;
                WS_SER_E: if (sen) begin
                    if (cnt_q == LAST_BIT) begin
                        cnt_d = '0;
                        st_d  = WS_SER_F;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                WS_SER_F: if (sen) begin
                    if (cnt_q == LAST_BIT) begin
                        cnt_d = '0;
                        st_d  = WS_SER_E;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // offset values
    always_comb begin
        e_d = e_q;
        f_d = f_q;
        if (mst_rst) begin
            e_d = ld ? OFS_HI : OFS_LO;
            f_d = ld ? OFS_HI : OFS_LO;
        end else if (!part_rst) begin
            unique case (st_q)
                WS_PAR_E: if (par_wr) e_d = par_val;
                WS_PAR_F: if (par_wr) f_d = par_val;
                WS_SER_E: if (sen) e_d = {fwft_si, e_q[OW-1:1]};
                WS_SER_F: if (sen) f_d = {fwft_si, f_q[OW-1:1]};
            endcase
        end
    end

    // state register
    always_ff @(posedge wclk) begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
    end

    always_ff @(posedge wclk) begin
        e_q <= e_d;
        f_q <= f_d;
    end

    assign empty_ofs = e_q;
    assign full_ofs  = f_q;

    AST_ONE_OFFSET: assert property (@(posedge wclk) disable iff (mst_rst)
        !mst_rst |=> !((e_q != $past(e_q)) && (f_q != $past(f_q)))); // R3

    AST_SER_NO_PAR: assert property (@(posedge wclk) disable iff (mst_rst)
        (serial_mode && !mst_rst && !part_rst && !sen) |=> ($stable(e_q) && $stable(f_q))); // R6

    AST_PRST_KEEPS: assert property (@(posedge wclk) disable iff (mst_rst)
        (part_rst && !mst_rst) |=> ($stable(e_q) && $stable(f_q))); // R7

    AST_CNT_RANGE: assert property (@(posedge wclk) disable iff (mst_rst)
        !mst_rst |=> (cnt_q <= LAST_BIT)); // R5

endmodule

// File: rtl/pfo_rd_port.sv
module pfo_rd_port
    import pfo_pkg::*;
#(
    parameter int DW = 18,
    parameter int OW = 17
) (
    input  logic          rclk,
    input  logic          mst_rst,
    input  logic          part_rst,
    input  logic          ld,
    input  logic          ren,
    input  logic [OW-1:0] empty_ofs,
    input  logic [OW-1:0] full_ofs,
    output logic [DW-1:0] dout
);

    rd_state_t     rs_q, rs_d;
    logic [DW-1:0] q_q, q_d;
    logic          rd_hit;

    assign rd_hit = ld && ren;

    always_comb begin
        rs_d = rs_q;
        q_d  = q_q;
        if (mst_rst || part_rst) begin
            rs_d = RS_EMPTY;
            q_d  = '0;
        end else if (rd_hit) begin
            unique case (rs_q)
                RS_EMPTY: begin
                    q_d  = DW'(empty_ofs);
                    rs_d = RS_FULL;
                end
                RS_FULL: begin
                    q_d  = DW'(full_ofs);
                    rs_d = RS_EMPTY;
                end
            endcase
        end
    end

    always_ff @(posedge rclk) begin
        rs_q <= rs_d;
    end

    always_ff @(posedge rclk) begin
        q_q <= q_d;
    end

    assign dout = q_q;

    AST_DOUT_HOLD: assert property (@(posedge rclk) disable iff (mst_rst)
        (!rd_hit && !part_rst && !mst_rst) |=> $stable(dout)); // R4

endmodule

// File: rtl/pfo_loader.sv
module pfo_loader #(
    parameter int DW = 18,
    parameter int OW = 17
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mst_rst,
    input  logic          part_rst,
    input  logic          ld,
    input  logic          wen,
    input  logic          ren,
    input  logic          sen,
    input  logic          fwft_si,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs,
    output logic          serial_mode,
    output logic          mem_wr_en,
    output logic          mem_rd_en
);

    logic          mode_w;
    logic [OW-1:0] e_w;
    logic [OW-1:0] f_w;

    pfo_mode_latch u_mode (
        .wclk        (wclk),
        .mst_rst     (mst_rst),
        .ld          (ld),
        .serial_mode (mode_w)
    );

    pfo_wr_ctrl #(.DW(DW), .OW(OW)) u_wr (
        .wclk        (wclk),
        .mst_rst     (mst_rst),
        .part_rst    (part_rst),
        .ld          (ld),
        .wen         (wen),
        .sen         (sen),
        .fwft_si     (fwft_si),
        .serial_mode (mode_w),
        .din         (din),
        .empty_ofs   (e_w),
        .full_ofs    (f_w)
    );

    pfo_rd_port #(.DW(DW), .OW(OW)) u_rd (
        .rclk      (rclk),
        .mst_rst   (mst_rst),
        .part_rst  (part_rst),
        .ld        (ld),
        .ren       (ren),
        .empty_ofs (e_w),
        .full_ofs  (f_w),
        .dout      (dout)
    );

    assign empty_ofs   = e_w;
    assign full_ofs    = f_w;
    assign serial_mode = mode_w;
    assign mem_wr_en   = wen && !ld;
    assign mem_rd_en   = ren && !ld;

endmodule

// File: tb/pfo_loader_test.sv
module pfo_loader_test;

    localparam int DW = 12;
    localparam int OW = 10;

    logic          clk = 1'b0;
    logic          mst_rst = 1'b1, part_rst = 1'b0, ld = 1'b0;
    logic          wen = 1'b0, ren = 1'b0, sen = 1'b0, si = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic [OW-1:0] eo, fo;
    logic          smode, mwr, mrd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pfo_loader #(.DW(DW), .OW(OW)) uut (
        .wclk(clk), .rclk(clk), .mst_rst(mst_rst), .part_rst(part_rst),
        .ld(ld), .wen(wen), .ren(ren), .sen(sen), .fwft_si(si), .din(din),
        .dout(dout), .empty_ofs(eo), .full_ofs(fo), .serial_mode(smode),
        .mem_wr_en(mwr), .mem_rd_en(mrd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        mst_rst = 0; part_rst = 0; ld = 0; wen = 0; ren = 0; sen = 0;
    endtask

    task automatic do_mst(input logic l);
        idle(); mst_rst = 1; ld = l; tick(); idle();
    endtask

    task automatic pwrite(input int v, input int hi);
        idle(); ld = 1; wen = 1; din = DW'(v | (hi << OW)); tick(); idle();
    endtask

    task automatic pread();
        idle(); ld = 1; ren = 1; tick(); idle();
    endtask

    task automatic shift_val(input int v, input int nbits);
        for (int b = 0; b < nbits; b++) begin
            idle(); sen = 1; si = ((v >> b) & 1) != 0; tick();
        end
        idle();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int pe, pf;
        tick();
        // R1 / R2: default with ld low
        do_mst(0);
        chk("R1 empty default lo", eo, 127);
        chk("R1 full default lo", fo, 127);
        chk("R1 dout cleared", dout, 0);
        chk("R2 parallel mode", smode, 0);
        do_mst(1);
        chk("R1 empty default hi", eo, 1023);
        chk("R1 full default hi", fo, 1023);
        chk("R2 serial mode", smode, 1);

        // R8 memory gating
        idle(); wen = 1; ren = 1; #1;
        chk("R8 wr pass", mwr, 1); chk("R8 rd pass", mrd, 1);
        ld = 1; #1;
        chk("R8 wr blocked", mwr, 0); chk("R8 rd blocked", mrd, 0);
        wen = 0; ren = 0; ld = 0; #1;
        chk("R8 wr idle", mwr, 0);

        // R3 / R4 parallel sweep
        do_mst(0);
        pf = 127;
        for (int i = 0; i < 12; i++) begin
            int ev, fv;
            ev = (i * 97 + 13) % 1024;
            fv = (i * 211 + 500) % 1024;
            pwrite(ev, i % 4);
            chk("R3 empty written", eo, ev);
            chk("R3 full untouched", fo, pf);
            pwrite(fv, (i + 1) % 4);
            chk("R3 full written", fo, fv);
            chk("R3 empty kept", eo, ev);
            pf = fv;
            pread();
            chk("R4 read empty", dout, ev);
            pread();
            chk("R4 read full", dout, fv);
            idle(); tick();
            chk("R4 dout holds", dout, fv);
            chk("R2 mode held parallel", smode, 0);
        end
        // R6 sen ignored in parallel mode
        pe = eo;
        shift_val(10'h3FF, 3);
        chk("R6 sen ignored empty", eo, pe);
        chk("R6 sen ignored full", fo, pf);

        // R5 / R6 serial sweep
        do_mst(1);
        pf = 1023;
        for (int p = 0; p < 6; p++) begin
            int ev, fv;
            ev = (p * 331 + 7) % 1024;
            fv = (p * 173 + 900) % 1024;
            shift_val(ev, OW);
            chk("R5 serial empty", eo, ev);
            chk("R5 serial full kept", fo, pf);
            shift_val(fv, OW);
            chk("R5 serial full", fo, fv);
            chk("R5 serial empty kept", eo, ev);
            pf = fv;
            pwrite(10'h2AA, 0);
            chk("R6 par ignored empty", eo, ev);
            chk("R6 par ignored full", fo, fv);
            pread();
            chk("R4 serial read empty", dout, ev);
            pread();
            chk("R4 serial read full", dout, fv);
        end

        // R7 partial reset mid serial
        pe = eo;
        shift_val(10'h3FF, 4);
        chk("R7 partial shift", eo, (pe >> 4) | (15 << 6));
        pe = eo;
        pread();
        idle(); part_rst = 1; tick(); idle();
        chk("R7 empty kept", eo, pe);
        chk("R7 full kept", fo, pf);
        chk("R7 mode kept", smode, 1);
        chk("R7 dout cleared", dout, 0);
        shift_val(10'h155, OW);
        chk("R7 serial restart empty", eo, 10'h155);
        shift_val(10'h0F3, OW);
        chk("R7 serial restart full", fo, 10'h0F3);
        pread();
        chk("R7 read restart", dout, 10'h155);

        // R7 partial reset in parallel mode
        do_mst(0);
        pwrite(300, 0);
        idle(); part_rst = 1; tick(); idle();
        chk("R7 par empty kept", eo, 300);
        chk("R7 par mode kept", smode, 0);
        pwrite(555, 1);
        chk("R7 par restart empty", eo, 555);
        chk("R7 par full default", fo, 127);

        // R9 master wins
        idle(); mst_rst = 1; part_rst = 1; ld = 1; tick(); idle();
        chk("R9 mode serial", smode, 1);
        chk("R9 empty default", eo, 1023);
        chk("R9 full default", fo, 1023);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule